// File: doc/BRIEF.md
# Serial Character Receiver with Long-Low Break Detection

This block is the receiving side of an asynchronous serial link. It watches one serial input that has already been synchronized to the system clock, and it uses an oversampling tick from an external rate source, sixteen ticks per bit by default. A falling edge starts a character. The start is checked again at mid-bit. Every later bit is sampled at the centre of its bit time. The receiver then builds a 7-bit or 8-bit character, with an optional parity bit, in either bit order. The finished character is placed in a receive buffer.

Three kinds of error are detected and held in sticky flags: parity, framing and overrun. A separate detector watches how long the line stays low. When the line has been low for a configurable number of bit times (eleven by default), it raises a sticky sync-break flag. An all-zero frame that turns out to be such a break is not delivered as a character. Two interrupt pulses are produced: one when a character completes, and one when a completing character carries any error.

Top module: `uart_rx_brk`

## Requirements
- R1: Character length is 8 bits when `cfg_len8`=1 and 7 bits when `cfg_len8`=0. `cfg_parity` selects the parity mode: 00 = no parity bit, 01 = even, 10 = odd, 11 = a parity bit that must be 0. The frame is start(0), data, optional parity, then stop(1). The configuration is latched at each start bit.
- R2: With `cfg_msb_first`=0 the first data bit received is bit 0 of the character. With `cfg_msb_first`=1 the first data bit received is the top bit of the character (bit 7, or bit 6 for 7-bit characters).
- R3: A start is confirmed by sampling the line again at mid-bit. A low pulse shorter than half a bit is ignored: no character, no interrupt and no error flag.
- R4: `err_parity` is set when the received parity bit does not match the selected mode.
- R5: `err_frame` is set when the stop bit is sampled low. The character is still moved into the buffer.
- R6: `err_overrun` is set when a character completes while the previous one is unread (no `buf_read` pulse since it arrived). The new character replaces the old one in `rx_data`.
- R7: `irq_rx_err` is a one-clock pulse, issued together with `irq_rx_done`, for a character that produced a parity, framing or overrun error.
- R8: `irq_rx_done` is a one-clock pulse for each character moved into `rx_data`. No character is received while `rx_en`=0.
- R9: `sync_brk` is set once the input has been low for 11 consecutive bit times. An all-zero frame whose low level reaches this length delivers no character and sets no framing error. An all-zero frame that is low for a shorter time is delivered with a framing error.
- R10: The error and break flags stay set until an `err_clear` pulse. With 7-bit characters, bit 7 of `rx_data` reads as 0.
- R11: After reset, `rx_data` is 0 and every flag and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| os_tick | input | 1 | Oversampling tick, OSR ticks per bit |
| rxd | input | 1 | Synchronized serial input, idle high |
| cfg_len8 | input | 1 | 1 = 8-bit characters, 0 = 7-bit characters |
| cfg_parity | input | 2 | Parity mode (00 none, 01 even, 10 odd, 11 zero) |
| cfg_msb_first | input | 1 | 1 = most significant bit received first |
| buf_read | input | 1 | Pulse: the buffer has been read |
| err_clear | input | 1 | Pulse: clear error and break flags |
| rx_data | output | 8 | Receive buffer |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_overrun | output | 1 | Sticky overrun error flag |
| sync_brk | output | 1 | Sticky sync-break flag |
| irq_rx_done | output | 1 | Character-complete pulse |
| irq_rx_err | output | 1 | Error interrupt pulse |

## Verification
Some properties are checked on every cycle by the assertions:
- an error pulse never appears without a set flag;
- completion pulses occur only while reception is enabled and only from the stop or hold state;
- the flags stay set until they are cleared;
- bit 7 is zero for 7-bit characters;
- the long-low indication is asserted only after the line was low.

Other properties can only be shown by the bench's scenarios: the correct bit values in each order and parity mode, rejection of a glitch, overwrite on overrun, and the boundary between a short all-zero frame and a real break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_ZERO = 2'b11
  } par_mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_brkdet.sv
module uart_rx_brkdet #(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic rxd,
  output logic long_low
);
  localparam int LIMIT = BRK_BITS * OSR;
  localparam int BW    = $clog2(LIMIT + 1);

  logic [BW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      low_cnt <= '0;
    end else if (rxd) begin
      low_cnt <= '0;
    end else if (tick && low_cnt != BW'(LIMIT)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign long_low = (low_cnt == BW'(LIMIT));

  // R9: long-low indication only follows a low line
  p_long_low_after_low_r9: assert property (@(posedge clk) disable iff (rst)
    long_low |-> !$past(rxd));
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd,
  input  logic       len8,
  input  logic [1:0] par_mode,
  input  logic       msb_first,
  input  logic       long_low,
  output logic       chr_valid,
  output rx_char_t   chr
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_bit;
  logic              len_q, msb_q, brk_seen, zero_pend;
  par_mode_t         par_q;
  logic [2:0]        last_idx, pos;
  logic              exp_par, perr_calc, all_zero;

  always_comb begin
    last_idx = len_q ? 3'd7 : 3'd6;
    pos      = msb_q ? (last_idx - idx) : idx;
    case (par_q)
      PAR_EVEN: exp_par = ^shreg;
      PAR_ODD:  exp_par = ~^shreg;
      default:  exp_par = 1'b0;
    endcase
    perr_calc = (par_q != PAR_NONE) && (par_bit != exp_par);
    all_zero  = (shreg == '0) && !par_bit;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      len_q     <= 1'b1;
      msb_q     <= 1'b0;
      par_q     <= PAR_NONE;
      brk_seen  <= 1'b0;
      zero_pend <= 1'b0;
      chr_valid <= 1'b0;
      chr       <= '0;
    end else begin
      chr_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tick && !rxd) begin
            cnt      <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            brk_seen <= 1'b0;
            len_q    <= len8;
            msb_q    <= msb_first;
            par_q    <= par_mode_t'(par_mode);
            state    <= S_START;
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              state <= rxd ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              shreg[pos] <= rxd;
              idx <= idx + 1'b1;
              if (idx == last_idx)
                state <= (par_q == PAR_NONE) ? S_STOP : S_PAR;
            end
          end
        end
        S_PAR: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              par_bit <= rxd;
              state   <= S_STOP;
            end
          end
        end
        S_STOP: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              if (rxd) begin
                chr_valid <= 1'b1;
                chr       <= '{data: shreg, perr: perr_calc, ferr: 1'b0};
                state     <= S_IDLE;
              end else if (all_zero) begin
                zero_pend <= 1'b1;
                brk_seen  <= long_low;
                state     <= S_HOLD;
              end else begin
                zero_pend <= 1'b0;
                chr_valid <= 1'b1;
                chr       <= '{data: shreg, perr: perr_calc, ferr: 1'b1};
                state     <= S_HOLD;
              end
            end
          end
        end
        S_HOLD: begin
          brk_seen <= brk_seen | long_low;
          if (rxd) begin
            state <= S_IDLE;
            if (zero_pend && !(brk_seen || long_low)) begin
              chr_valid <= 1'b1;
              chr       <= '{data: shreg, perr: perr_calc, ferr: 1'b1};
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: short characters never carry a top bit
  p_short_top_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && !len_q) |-> !chr.data[7]);

  // R8: a character completes only from the stop or hold phase
  p_valid_origin_r8: assert property (@(posedge clk) disable iff (rst)
    chr_valid |-> ($past(state) == S_STOP || $past(state) == S_HOLD));
endmodule

// File: rtl/uart_rx_bufctl.sv
module uart_rx_bufctl
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              chr_valid,
  input  rx_char_t          chr,
  input  logic              long_low,
  input  logic              rd,
  input  logic              clr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              perr_f,
  output logic              ferr_f,
  output logic              ovr_f,
  output logic              brk_f,
  output logic              done_irq,
  output logic              err_irq
);
  logic full, ovr_set;

  assign ovr_set = chr_valid && full && !rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      full     <= 1'b0;
      perr_f   <= 1'b0;
      ferr_f   <= 1'b0;
      ovr_f    <= 1'b0;
      brk_f    <= 1'b0;
      done_irq <= 1'b0;
      err_irq  <= 1'b0;
    end else begin
      if (chr_valid) begin
        rx_data <= chr.data;
        full    <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
      perr_f   <= (perr_f & ~clr) | (chr_valid & chr.perr);
      ferr_f   <= (ferr_f & ~clr) | (chr_valid & chr.ferr);
      ovr_f    <= (ovr_f & ~clr) | ovr_set;
      brk_f    <= (brk_f & ~clr) | long_low;
      done_irq <= chr_valid;
      err_irq  <= chr_valid & (chr.perr | chr.ferr | ovr_set);
    end
  end

  // R7: an error pulse is always backed by a set flag
  p_err_has_flag_r7: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> (perr_f || ferr_f || ovr_f));

  // R7: the error pulse accompanies a completion
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> done_irq);

  // R8: completions only while enabled
  p_done_enabled_r8: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $past(en));

  // R10: flags hold until cleared
  p_sticky_par_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(perr_f) && !$past(clr)) |-> perr_f);
  p_sticky_brk_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(brk_f) && !$past(clr)) |-> brk_f);

  // R6: overrun rises only together with a new completion
  p_ovr_on_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_f) |-> done_irq);
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       cfg_len8,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_msb_first,
  input  logic       buf_read,
  input  logic       err_clear,
  output logic [7:0] rx_data,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       sync_brk,
  output logic       irq_rx_done,
  output logic       irq_rx_err
);
  logic     long_low;
  logic     chr_valid;
  rx_char_t chr;

  uart_rx_brkdet #(.OSR(OSR), .BRK_BITS(BRK_BITS)) brkdet_i (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_en),
    .tick     (os_tick),
    .rxd      (rxd),
    .long_low (long_low)
  );

  uart_rx_deframer #(.OSR(OSR)) deframer_i (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .tick      (os_tick),
    .rxd       (rxd),
    .len8      (cfg_len8),
    .par_mode  (cfg_parity),
    .msb_first (cfg_msb_first),
    .long_low  (long_low),
    .chr_valid (chr_valid),
    .chr       (chr)
  );

  uart_rx_bufctl bufctl_i (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .chr_valid (chr_valid),
    .chr       (chr),
    .long_low  (long_low),
    .rd        (buf_read),
    .clr       (err_clear),
    .rx_data   (rx_data),
    .perr_f    (err_parity),
    .ferr_f    (err_frame),
    .ovr_f     (err_overrun),
    .brk_f     (sync_brk),
    .done_irq  (irq_rx_done),
    .err_irq   (irq_rx_err)
  );
endmodule

// File: tb/uart_rx_brk_tb_top.sv
module uart_rx_brk_tb_top;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic cfg_len8 = 1'b1;
  logic [1:0] cfg_parity = 2'b00;
  logic cfg_msb_first = 1'b0;
  logic buf_read = 1'b0;
  logic err_clear = 1'b0;
  logic [7:0] rx_data;
  logic err_parity, err_frame, err_overrun, sync_brk, irq_rx_done, irq_rx_err;

  int errors = 0;
  int checks = 0;
  int n_done = 0;
  int n_err = 0;
  int tdiv_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    os_tick  <= (tdiv_cnt == TDIV - 1);
    if (irq_rx_done) n_done <= n_done + 1;
    if (irq_rx_err) n_err <= n_err + 1;
  end

  uart_rx_brk dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
    .cfg_len8(cfg_len8), .cfg_parity(cfg_parity), .cfg_msb_first(cfg_msb_first),
    .buf_read(buf_read), .err_clear(err_clear), .rx_data(rx_data),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .sync_brk(sync_brk), .irq_rx_done(irq_rx_done), .irq_rx_err(irq_rx_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int nbits);
    rxd = b;
    repeat (nbits * BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic par_flip, input logic stop_v);
    int nb;
    logic [7:0] m;
    logic p;
    nb = cfg_len8 ? 8 : 7;
    m = cfg_len8 ? d : {1'b0, d[6:0]};
    send_bit(1'b0, 1);
    for (int i = 0; i < nb; i++) send_bit(cfg_msb_first ? m[nb-1-i] : m[i], 1);
    if (cfg_parity != 2'b00) begin
      case (cfg_parity)
        2'b01: p = ^m;
        2'b10: p = ~^m;
        default: p = 1'b0;
      endcase
      send_bit(p ^ par_flip, 1);
    end
    send_bit(stop_v, 1);
    send_bit(1'b1, 2);
  endtask

  task automatic pulse_read();
    buf_read = 1'b1; @(negedge clk); buf_read = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clear();
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
  endtask

  task automatic set_cfg(input logic l8, input logic [1:0] pm, input logic msb);
    cfg_len8 = l8; cfg_parity = pm; cfg_msb_first = msb;
  endtask

  task automatic t_reset();
    check("R11 rx_data", rx_data, 0);
    check("R11 flags", {err_parity, err_frame, err_overrun, sync_brk}, 0);
    check("R11 irqs", {irq_rx_done, irq_rx_err}, 0);
  endtask

  task automatic t_basic_8n1();
    int d0;
    d0 = n_done;
    set_cfg(1, 2'b00, 0);
    send_frame(8'hA5, 0, 1);
    check("R1 8N1 data", rx_data, 8'hA5);
    check("R8 done pulse", n_done - d0, 1);
    check("R1 no errors", {err_parity, err_frame, err_overrun}, 0);
    pulse_read();
  endtask

  task automatic t_order_7e();
    set_cfg(0, 2'b01, 1);
    send_frame(8'hB5, 0, 1);
    check("R2 R10 7-bit msb-first data", rx_data, 8'h35);
    check("R1 even parity ok", err_parity, 0);
    pulse_read();
    set_cfg(1, 2'b00, 1);
    send_frame(8'h1E, 0, 1);
    check("R2 8-bit msb-first data", rx_data, 8'h1E);
    pulse_read();
  endtask

  task automatic t_parity();
    int e0;
    e0 = n_err;
    set_cfg(1, 2'b10, 0);
    send_frame(8'h3C, 0, 1);
    check("R1 odd parity ok", err_parity, 0);
    pulse_read();
    send_frame(8'h3C, 1, 1);
    check("R4 odd parity error", err_parity, 1);
    check("R7 error pulse", n_err - e0, 1);
    pulse_clear();
    check("R10 parity cleared", err_parity, 0);
    pulse_read();
    set_cfg(1, 2'b11, 0);
    send_frame(8'h81, 1, 1);
    check("R4 zero-parity mode error", err_parity, 1);
    check("R4 data kept", rx_data, 8'h81);
    pulse_clear();
    pulse_read();
  endtask

  task automatic t_frame();
    int d0;
    d0 = n_done;
    set_cfg(1, 2'b00, 0);
    send_frame(8'h3C, 0, 0);
    check("R5 framing error", err_frame, 1);
    check("R5 data delivered", rx_data, 8'h3C);
    check("R5 delivery count", n_done - d0, 1);
    check("R10 frame flag held", err_frame, 1);
    pulse_clear();
    pulse_read();
  endtask

  task automatic t_overrun();
    int e0;
    set_cfg(1, 2'b00, 0);
    send_frame(8'h11, 0, 1);
    check("R6 no overrun yet", err_overrun, 0);
    e0 = n_err;
    send_frame(8'h22, 0, 1);
    check("R6 overrun flag", err_overrun, 1);
    check("R6 overwrite", rx_data, 8'h22);
    check("R7 overrun pulse", n_err - e0, 1);
    pulse_clear();
    pulse_read();
    send_frame(8'h33, 0, 1);
    check("R6 no overrun after read", err_overrun, 0);
    pulse_read();
  endtask

  task automatic t_glitch();
    int d0;
    d0 = n_done;
    rxd = 1'b0;
    repeat (5 * TDIV) @(negedge clk);
    send_bit(1'b1, 3);
    check("R3 glitch no char", n_done - d0, 0);
    check("R3 glitch no flag", {err_parity, err_frame, err_overrun, sync_brk}, 0);
  endtask

  task automatic t_short_zero();
    int d0;
    d0 = n_done;
    set_cfg(1, 2'b00, 0);
    send_frame(8'h00, 0, 0);
    check("R9 short zero framing", err_frame, 1);
    check("R9 short zero no break", sync_brk, 0);
    check("R9 short zero delivered", n_done - d0, 1);
    pulse_clear();
    pulse_read();
  endtask

  task automatic t_break();
    int d0;
    d0 = n_done;
    send_bit(1'b0, 13);
    send_bit(1'b1, 3);
    check("R9 break flag", sync_brk, 1);
    check("R9 break no framing", err_frame, 0);
    check("R9 break no char", n_done - d0, 0);
    pulse_clear();
    check("R10 break cleared", sync_brk, 0);
  endtask

  task automatic t_disabled();
    int d0;
    d0 = n_done;
    rx_en = 1'b0;
    @(negedge clk);
    send_frame(8'h5A, 0, 1);
    check("R8 disabled no char", n_done - d0, 0);
    rx_en = 1'b1;
    @(negedge clk);
    send_frame(8'h5A, 0, 1);
    check("R8 enabled again", rx_data, 8'h5A);
    pulse_read();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    send_bit(1'b1, 2);
    t_basic_8n1();
    t_order_7e();
    t_parity();
    t_frame();
    t_overrun();
    t_glitch();
    t_short_zero();
    t_break();
    t_disabled();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule